// File: doc/BRIEF.md
# Smoothly Ramping Stereo Attenuator

This block scales a stream of 20-bit two's-complement audio samples by a gain set from an 11-bit attenuation code. The applied gain is linear in the code, code/1024, so code 0 mutes the stream and code 0x400 passes it unchanged. A code written by the control side does not take effect at once. It becomes the target, and a separate level counter walks toward it by one step per stereo frame. Any code written during a ramp turns the walk from wherever the level is at that moment. A boost input multiplies the gain by four (+12.04 dB), and the boosted result is clamped to the 20-bit range.

Samples enter and leave over valid/ready handshakes, each carrying a channel flag (high for the right channel). Each accepted sample produces exactly one output word one cycle later through a single output register. The input is ready whenever that register is empty or is being drained in the same cycle. Back-pressure therefore propagates to the input with no extra buffering, and a stalled output word holds steady. Two zeroing paths override the scaled value: a direct-mute input, and a start-up window that blanks the first 3072 words accepted after reset.

Top module: `atten_smooth_top`

## Requirements
- R1: With boost low, an accepted sample x under level L produces floor(x*L/1024), rounded toward negative infinity.
- R2: Codes from 0x401 to 0x7FF are stored as 0x400, so the level never rises above unity.
- R3: With boost high, the output is floor(x*L/256), clamped to the range -524288 to 524287.
- R4: The level moves by exactly one step toward the target each time a right-channel sample is accepted (in_right high). Left-channel samples do not move it. Both samples of a frame use the level held before that frame's step. A code written in one cycle steers steps from the next cycle on.
- R5: A code written before the target is reached continues the ramp from the current level toward the new target.
- R6: During reset, out_valid and out_data are 0 and in_ready is 1. After reset both the target and the level are 0x400.
- R7: A word accepted while dmute is high comes out as zero. A word accepted after dmute falls carries normal data.
- R8: The first 3072 words accepted after reset come out as zero. The 3073rd word and every later word carry normal data.
- R9: in_ready equals !out_valid || out_ready. A word appears on the output one cycle after acceptance. While out_valid is high and out_ready is low, the output word is held unchanged.
- R10: A ramp from unity to mute takes 1024 frames. After 1023 frames the level is 1, and after 1024 frames it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 20 | Signed input sample |
| in_right | input | 1 | Sample belongs to the right channel |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 20 | Signed scaled sample |
| out_right | output | 1 | Channel flag of the output word |
| tgt_wr | input | 1 | Strobe that loads a new attenuation code |
| tgt_code | input | 11 | Attenuation code |
| boost_en | input | 1 | Selects the x4 gain range |
| dmute | input | 1 | Direct mute |

## Verification
Every output result is due on the rising edge that accepts the sample. The bench drives inputs on falling edges and reads the outputs on the falling edge that follows acceptance, so each sample is checked exactly one register stage after it was taken. A code write lands one edge after its strobe, and the ramp then moves only on accepted right-channel words. The bench therefore keeps its own target and level model, which it advances on each right-channel send. The expected value for each word uses the level that held before that word's step. For stalls, the bench reads in_ready combinationally and watches the held word for several cycles before releasing out_ready.

// File: rtl/atten_pkg.sv
package atten_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_dir_e;

endpackage

// File: rtl/atten_ramp.sv
module atten_ramp
  import atten_pkg::*;
#(
  parameter int CODE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_wr,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic              step_en,
  output logic [CODE_W-1:0] level
);
  localparam logic [CODE_W-1:0] UNITY_C = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] tgt_q;
  logic [CODE_W-1:0] lvl_q;
  logic [CODE_W-1:0] tgt_clamped;
  step_dir_e         dir;

  assign tgt_clamped = (tgt_code > UNITY_C) ? UNITY_C : tgt_code;

  always_comb begin
    if (lvl_q < tgt_q)      dir = STEP_UP;
    else if (lvl_q > tgt_q) dir = STEP_DOWN;
    else                    dir = STEP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= UNITY_C;
      lvl_q <= UNITY_C;
    end else begin
      if (tgt_wr) tgt_q <= tgt_clamped;
      if (step_en) begin
        unique case (dir)
          STEP_UP:   lvl_q <= lvl_q + 1'b1;
          STEP_DOWN: lvl_q <= lvl_q - 1'b1;
          default:   lvl_q <= lvl_q;
        endcase
      end
    end
  end

  assign level = lvl_q;

  assert_level_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= UNITY_C);

  assert_target_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_q <= UNITY_C);

  assert_no_step_off_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(lvl_q));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> ($stable(lvl_q) || (lvl_q == $past(lvl_q) + 1'b1) ||
                 (lvl_q + 1'b1 == $past(lvl_q))));

endmodule

// File: rtl/atten_scale.sv
module atten_scale #(
  parameter int DATA_W = 20,
  parameter int CODE_W = 11
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [CODE_W-1:0] level,
  input  logic                     boost,
  output logic signed [DATA_W-1:0] result,
  output logic                     clipped
);
  localparam int PROD_W   = DATA_W + CODE_W + 1;
  localparam int SH_NORM  = CODE_W - 1;
  localparam int SH_BOOST = CODE_W - 3;
  localparam logic signed [PROD_W-1:0] MAXV =
    {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] MINV = ~MAXV;

  logic signed [PROD_W-1:0] xs;
  logic signed [PROD_W-1:0] gs;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    xs      = PROD_W'(sample);
    gs      = PROD_W'({1'b0, level});
    prod    = xs * gs;
    shifted = boost ? (prod >>> SH_BOOST) : (prod >>> SH_NORM);
    clipped = 1'b0;
    if (shifted > MAXV) begin
      result  = MAXV[DATA_W-1:0];
      clipped = 1'b1;
    end else if (shifted < MINV) begin
      result  = MINV[DATA_W-1:0];
      clipped = 1'b1;
    end else begin
      result  = shifted[DATA_W-1:0];
    end
  end

  always_comb begin
    if (!boost && level <= {1'b1, {(CODE_W-1){1'b0}}})
      assert_no_clip_at_unity_R1: assert (!clipped);
  end

endmodule

// File: rtl/atten_mute_win.sv
module atten_mute_win #(
  parameter int MUTE_WORDS = 3072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic word_acc,
  output logic win_open
);
  generate
    if (MUTE_WORDS == 0) begin : g_none
      assign win_open = 1'b1;
    end else begin : g_count
      localparam int CNT_W = $clog2(MUTE_WORDS + 1);
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MUTE_WORDS);

      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (word_acc && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end

      assign win_open = (cnt_q == LIMIT);

      assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

      assert_open_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |=> win_open);

      assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_acc |=> $stable(cnt_q));
    end
  endgenerate

endmodule

// File: rtl/atten_smooth_top.sv
module atten_smooth_top #(
  parameter int DATA_W     = 20,
  parameter int CODE_W     = 11,
  parameter int MUTE_WORDS = 3072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_right,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_right,
  input  logic              tgt_wr,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic              boost_en,
  input  logic              dmute
);
  logic                     acc;
  logic                     step_en;
  logic [CODE_W-1:0]        level;
  logic signed [DATA_W-1:0] scaled;
  logic                     clipped;
  logic                     win_open;
  logic                     blank;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign step_en  = acc && in_right;
  assign blank    = dmute || !win_open;

  atten_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tgt_wr   (tgt_wr),
    .tgt_code (tgt_code),
    .step_en  (step_en),
    .level    (level)
  );

  atten_scale #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_scale (
    .sample  ($signed(in_data)),
    .level   (level),
    .boost   (boost_en),
    .result  (scaled),
    .clipped (clipped)
  );

  atten_mute_win #(.MUTE_WORDS(MUTE_WORDS)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_acc (acc),
    .win_open (win_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_right <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (acc) begin
        out_data  <= blank ? '0 : scaled;
        out_right <= in_right;
      end
    end
  end

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_right)));

  assert_accept_to_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_dmute_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dmute) |=> (out_data == '0));

  assert_window_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !win_open) |=> (out_data == '0));

  assert_unity_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !blank && !boost_en && level == {1'b1, {(CODE_W-1){1'b0}}})
      |=> (out_data == $past(in_data)));

endmodule

// File: tb/atten_smooth_top_tb_top.sv
module atten_smooth_top_tb_top;
  localparam int DW    = 20;
  localparam int CW    = 11;
  localparam int MW    = 3072;
  localparam int UNITY = 1024;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_ready, in_right = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_ready = 1'b1, out_right;
  logic [DW-1:0] out_data;
  logic          tgt_wr = 1'b0, boost_en = 1'b0, dmute = 1'b0;
  logic [CW-1:0] tgt_code = '0;

  int checks = 0, errors = 0;
  int exp_lvl = UNITY, exp_tgt = UNITY;
  bit done = 1'b0;

  atten_smooth_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_right(in_right), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_right(out_right),
    .tgt_wr(tgt_wr), .tgt_code(tgt_code), .boost_en(boost_en), .dmute(dmute)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(input longint x, input int l, input bit b);
    longint p = x * l;
    longint q = b ? (p >>> 8) : (p >>> 10);
    if (q > 524287) q = 524287;
    if (q < -524288) q = -524288;
    return q;
  endfunction

  task automatic write_tgt(input int c);
    @(negedge clk);
    tgt_wr = 1'b1; tgt_code = c[CW-1:0];
    @(posedge clk); #1;
    tgt_wr = 1'b0;
    exp_tgt = (c > UNITY) ? UNITY : c;
  endtask

  task automatic step_model();
    if (exp_lvl < exp_tgt) exp_lvl++;
    else if (exp_lvl > exp_tgt) exp_lvl--;
  endtask

  task automatic send(input int x, input bit r, input bit zero_exp, input string req);
    longint e;
    @(negedge clk);
    in_valid = 1'b1; in_data = x[DW-1:0]; in_right = r;
    e = zero_exp ? 0 : model(x, exp_lvl, boost_en);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1 && out_right == r, req, longint'(out_valid), 1);
    chk(longint'($signed(out_data)) == e, req, longint'($signed(out_data)), e);
    if (r) step_model();
  endtask

  task automatic frame(input int x, input string req);
    send(x, 1'b0, 1'b0, req);
    send(x, 1'b1, 1'b0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lv[10] = '{0, 1, 3, 255, 256, 511, 513, 768, 1023, 1024};
    int xv[14] = '{0, 1, -1, 5, -5, 1023, -1024, 262143, -262144,
                   524287, -524288, 131071, -131073, 300001};
    repeat (3) @(negedge clk);
    // R6: reset state
    chk(out_valid == 0, "R6", longint'(out_valid), 0);
    chk(out_data == 0, "R6", longint'(out_data), 0);
    chk(in_ready == 1, "R6", longint'(in_ready), 1);
    rst_n = 1'b1;

    // R8: start-up window, words 1..3072 zero
    for (int i = 0; i < MW; i++) send(i * 37 - 50000, i[0], 1'b1, "R8");
    // R8 / R6: word 3073 normal at reset level 0x400
    send(12345, 1'b0, 1'b0, "R8");
    send(-777, 1'b1, 1'b0, "R6");

    // R10: full ramp from unity to mute
    write_tgt(0);
    for (int f = 0; f < 1023; f++) frame(200000 - f, "R4");
    @(negedge clk); in_valid = 1'b1; in_data = DW'(1024); in_right = 1'b0;
    @(posedge clk); #1; in_valid = 1'b0; @(negedge clk);
    chk($signed(out_data) == 1, "R10", longint'($signed(out_data)), 1);
    send(1024, 1'b1, 1'b0, "R10");
    send(1024, 1'b0, 1'b1, "R10");

    // R1 / R3: sweep levels, data and both gain ranges
    foreach (lv[k]) begin
      write_tgt(lv[k]);
      while (exp_lvl != exp_tgt) frame(4096, "R4");
      for (int b = 0; b < 2; b++) begin
        boost_en = b[0];
        foreach (xv[j]) send(xv[j], 1'b0, 1'b0, b ? "R3" : "R1");
      end
      boost_en = 1'b0;
    end

    // R2: codes above unity clamp to unity
    write_tgt(12'h7FF);
    for (int f = 0; f < 3; f++) frame(1024, "R2");
    send(1024, 1'b0, 1'b0, "R2");
    write_tgt(12'h401);
    for (int f = 0; f < 3; f++) frame(-1024, "R2");

    // R5: retarget mid-ramp
    write_tgt(1000);
    for (int f = 0; f < 10; f++) frame(300000, "R5");
    write_tgt(1020);
    for (int f = 0; f < 30; f++) frame(300000, "R5");
    @(negedge clk); in_valid = 1'b1; in_data = DW'(1024); in_right = 1'b0;
    @(posedge clk); #1; in_valid = 1'b0; @(negedge clk);
    chk($signed(out_data) == 1020, "R5", longint'($signed(out_data)), 1020);

    // R7: direct mute
    dmute = 1'b1;
    send(5000, 1'b0, 1'b1, "R7");
    send(5000, 1'b1, 1'b1, "R7");
    dmute = 1'b0;
    send(5000, 1'b0, 1'b0, "R7");

    // R9: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    send(777, 1'b0, 1'b0, "R9");
    in_valid = 1'b1; in_data = DW'(-4000); in_right = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(in_ready == 0, "R9", longint'(in_ready), 0);
      chk($signed(out_data) == model(777, exp_lvl, 1'b0), "R9",
          longint'($signed(out_data)), model(777, exp_lvl, 1'b0));
    end
    out_ready = 1'b1;
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid && $signed(out_data) == model(-4000, exp_lvl, 1'b0), "R9",
        longint'($signed(out_data)), model(-4000, exp_lvl, 1'b0));
    step_model();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule